// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

A 64-bit adder whose carry chain is cut at 8-bit segment boundaries so that one adder can work on packed vectors. The same datapath handles eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane can subtract as well as add. Lanes can read their operands as signed or unsigned values. Each lane either wraps modulo its width or clamps to the nearest representable extreme when the true result does not fit.

Subtraction inverts operand B and forces the carry into the bottom segment of each lane to 1. For addition that carry is forced to 0. Inside a lane, segments pass their carries upward as a normal ripple. Each lane reports its overflow, and the flag is copied onto every byte position the lane covers. The result and the overflow mask are registered, so both appear one clock after the operands.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel_i` picks the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. Lane k covers bits [k*W +: W]. No carry or borrow crosses from one lane into the next.
- R2: With `sat_en_i`=0, each lane returns its sum or difference modulo 2^W.
- R3: Bit j of `ovf_o` is the overflow flag of the lane that holds byte j, so all bits of one lane are equal. With `signed_i`=1 the flag means two's-complement overflow. With `signed_i`=0 it means carry-out on add or borrow on subtract. The flag is reported whether or not saturation is on.
- R4: With `sat_en_i`=1 and `signed_i`=1, a lane that overflows positively returns the largest positive value (0x7F..FF). A lane that overflows negatively returns the smallest negative value (0x80..00). A lane that does not overflow returns the exact result.
- R5: With `sat_en_i`=1 and `signed_i`=0, an overflowing lane returns all ones on add and zero on subtract.
- R6: `sub_i`=1 computes A minus B in every lane. `sub_i`=0 computes A plus B.
- R7: `res_o` and `ovf_o` are updated on the rising clock edge that follows the operands, a latency of one cycle. An active-low asynchronous reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | Operand A, packed lanes |
| b_i | input | 64 | Operand B, packed lanes |
| lane_sel_i | input | 2 | Lane width select |
| sat_en_i | input | 1 | 1 = saturate, 0 = wrap |
| signed_i | input | 1 | 1 = signed lanes |
| sub_i | input | 1 | 1 = subtract |
| res_o | output | 64 | Registered result vector |
| ovf_o | output | 8 | Registered overflow flag per byte |

## Verification
Some vectors overflow the bottom byte and then check that the byte above is unchanged. A carry leaking across a lane boundary would change that byte. In 16-bit and 32-bit mode, the operands are chosen so that a carry has to ripple through an inner byte boundary. A chain cut at every byte would lose that carry. Signed vectors overflow in both directions, in both add and subtract, to catch a swapped or partial clamp value: for example, all ones in the top byte where 0x7F belongs. Unsigned subtract vectors that borrow are there to catch an overflow flag taken from the raw carry-out rather than its inverse. Another check confirms that code 2'b11 acts as 32-bit mode. A reset applied in the middle of a run must clear the outputs at once, without waiting for a clock.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B32X = 2'b11
  } lane_sel_e;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_add_pkg::*;
#(
  parameter int NUM_SEG = 8,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  lane_sel_e               lane_sel_i,
  output logic [NUM_SEG-1:0]      first_o,
  output logic [NUM_SEG-1:0][IDX_W-1:0] top_idx_o
);
  int span;
  always_comb begin
    unique case (lane_sel_i)
      LANE_B8:  span = 1;
      LANE_B16: span = 2;
      default:  span = 4;
    endcase
    for (int i = 0; i < NUM_SEG; i++) begin
      first_o[i]   = ((i % span) == 0);
      top_idx_o[i] = IDX_W'(i | (span - 1));
    end
  end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  localparam int DATA_W = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic               sub_i,
  input  logic [NUM_SEG-1:0] first_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] sovf_o,
  output logic [NUM_SEG-1:0] uovf_o
);
  logic [NUM_SEG-1:0] cout;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    logic [SEG_W-1:0] bx;
    logic             cin;
    logic [SEG_W:0]   wide;

    assign bx = sub_i ? ~b_i[LO +: SEG_W] : b_i[LO +: SEG_W];
    // carry is cut at lane starts and re-injected as the subtract bit
    if (s == 0) begin : g_base
      assign cin = sub_i;
    end else begin : g_link
      assign cin = first_i[s] ? sub_i : cout[s-1];
    end
    assign wide = {1'b0, a_i[LO +: SEG_W]} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
    assign sum_o[LO +: SEG_W] = wide[SEG_W-1:0];
    assign cout[s]   = wide[SEG_W];
    assign sovf_o[s] = (a_i[LO+SEG_W-1] == bx[SEG_W-1]) &&
                       (wide[SEG_W-1] != a_i[LO+SEG_W-1]);
    assign uovf_o[s] = sub_i ? ~wide[SEG_W] : wide[SEG_W];
  end
endmodule

// File: rtl/simd_sat_select.sv
module simd_sat_select #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  localparam int DATA_W = SEG_W * NUM_SEG,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [DATA_W-1:0]             sum_i,
  input  logic [DATA_W-1:0]             a_i,
  input  logic [NUM_SEG-1:0]            sovf_i,
  input  logic [NUM_SEG-1:0]            uovf_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0] top_idx_i,
  input  logic                          sat_en_i,
  input  logic                          signed_i,
  input  logic                          sub_i,
  output logic [DATA_W-1:0]             res_o,
  output logic [NUM_SEG-1:0]            ovf_o
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_sel
    localparam int LO = s * SEG_W;
    logic [IDX_W-1:0] top;
    logic             is_top, neg, ovf;
    logic [SEG_W-1:0] clamp;

    assign top    = top_idx_i[s];
    assign is_top = (top == IDX_W'(s));
    assign neg    = a_i[SEG_W*top + SEG_W - 1];
    assign ovf    = signed_i ? sovf_i[top] : uovf_i[top];

    always_comb begin
      if (signed_i) begin
        if (neg) clamp = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
        else     clamp = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : '1;
      end else begin
        clamp = sub_i ? '0 : '1;
      end
    end

    assign ovf_o[s]           = ovf;
    assign res_o[LO +: SEG_W] = (sat_en_i && ovf) ? clamp : sum_i[LO +: SEG_W];
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  localparam int DATA_W = SEG_W * NUM_SEG,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              sat_en_i,
  input  logic              signed_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NUM_SEG-1:0] ovf_o
);
  logic [NUM_SEG-1:0]            first;
  logic [NUM_SEG-1:0][IDX_W-1:0] top_idx;
  logic [DATA_W-1:0]             sum, res_d;
  logic [NUM_SEG-1:0]            sovf, uovf, ovf_d;

  simd_lane_map #(.NUM_SEG(NUM_SEG)) u_map (
    .lane_sel_i (lane_sel_e'(lane_sel_i)),
    .first_o    (first),
    .top_idx_o  (top_idx)
  );

  simd_seg_adder #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .first_i (first),
    .sum_o   (sum),
    .sovf_o  (sovf),
    .uovf_o  (uovf)
  );

  simd_sat_select #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_sat (
    .sum_i     (sum),
    .a_i       (a_i),
    .sovf_i    (sovf),
    .uovf_i    (uovf),
    .top_idx_i (top_idx),
    .sat_en_i  (sat_en_i),
    .signed_i  (signed_i),
    .sub_i     (sub_i),
    .res_o     (res_d),
    .ovf_o     (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      ovf_o <= '0;
    end else begin
      res_o <= res_d;
      ovf_o <= ovf_d;
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  localparam int DATA_W = SEG_W * NUM_SEG
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [1:0]         lane_sel_i,
  input logic               sat_en_i,
  input logic               signed_i,
  input logic               sub_i,
  input logic [DATA_W-1:0]  res_o,
  input logic [NUM_SEG-1:0] ovf_o
);
  logic [DATA_W-1:0] a_q, b_q;
  logic [1:0]        sel_q;
  logic              sat_q, sgn_q, sub_q, primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; sel_q <= '0;
      sat_q <= 1'b0; sgn_q <= 1'b0; sub_q <= 1'b0; primed <= 1'b0;
    end else begin
      a_q <= a_i; b_q <= b_i; sel_q <= lane_sel_i;
      sat_q <= sat_en_i; sgn_q <= signed_i; sub_q <= sub_i; primed <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_byte
    logic [SEG_W-1:0] exp_wrap, got;
    assign exp_wrap = sub_q ? a_q[k*SEG_W +: SEG_W] - b_q[k*SEG_W +: SEG_W]
                            : a_q[k*SEG_W +: SEG_W] + b_q[k*SEG_W +: SEG_W];
    assign got = res_o[k*SEG_W +: SEG_W];

    assert_wrap8_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sel_q == 2'b00 && !sat_q |-> got == exp_wrap);
    assert_exact8_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sel_q == 2'b00 && !ovf_o[k] |-> got == exp_wrap);
    assert_ssat8_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sel_q == 2'b00 && sat_q && sgn_q && ovf_o[k] |->
      (got == {1'b0, {(SEG_W-1){1'b1}}} || got == {1'b1, {(SEG_W-1){1'b0}}}));
    assert_usat_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sat_q && !sgn_q && !sub_q && ovf_o[k] |-> got == '1);
    assert_usat_sub_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sat_q && !sgn_q && sub_q && ovf_o[k] |-> got == '0);
  end

  for (genvar j = 0; j < NUM_SEG / 2; j++) begin : g_pair
    assert_lane_mask16_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sel_q == 2'b01 |-> ovf_o[2*j] == ovf_o[2*j+1]);
  end

  for (genvar j = 0; j < NUM_SEG / 4; j++) begin : g_quad
    assert_lane_mask32_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && sel_q[1] |-> (ovf_o[4*j +: 4] == 4'h0 || ovf_o[4*j +: 4] == 4'hF));
  end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_i        (a_i),
  .b_i        (b_i),
  .lane_sel_i (lane_sel_i),
  .sat_en_i   (sat_en_i),
  .signed_i   (signed_i),
  .sub_i      (sub_i),
  .res_o      (res_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  lane_sel_i = 2'b00;
  logic        sat_en_i = 1'b0, signed_i = 1'b0, sub_i = 1'b0;
  logic [63:0] res_o;
  logic [7:0]  ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_sat_adder u0 (.*);

  // {tag, sel, sat, sgn, sub, a, b, exp_res, exp_ovf}
  typedef logic [32+2+3+64*3+8-1:0] vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    {"R1  ", 2'b00, 3'b000, 64'h01020304050607FF, 64'h0101010101010101, 64'h0203040506070800, 8'h01},
    {"R5  ", 2'b00, 3'b100, 64'h01020304050607FF, 64'h0101010101010101, 64'h02030405060708FF, 8'h01},
    {"R2  ", 2'b01, 3'b000, 64'h00FFFFFF12340001, 64'h000100010001FFFF, 64'h0100000012350000, 8'h33},
    {"R4  ", 2'b10, 3'b110, 64'h7FFFFFF080000000, 64'h00000100FFFFFFFF, 64'h7FFFFFFF80000000, 8'hFF},
    {"R6  ", 2'b00, 3'b111, 64'h807F001005FF7F80, 64'h01FF01200301807F, 64'h807FFFF002FE7F80, 8'hC3},
    {"R5  ", 2'b01, 3'b101, 64'h000510000000FFFF, 64'h00060FFF00000001, 64'h000000010000FFFE, 8'hC0},
    {"R6  ", 2'b10, 3'b001, 64'h0000000000000010, 64'h0000000100000011, 64'hFFFFFFFFFFFFFFFF, 8'hFF},
    {"R3  ", 2'b01, 3'b010, 64'h7FFF80000001FFFF, 64'h0001FFFF00020001, 64'h80007FFF00030000, 8'hF0},
    {"R4  ", 2'b10, 3'b110, 64'h00FFFFFFFFFFFFFF, 64'h0000000100000001, 64'h0100000000000000, 8'h00},
    {"R1  ", 2'b11, 3'b110, 64'h00FFFFFFFFFFFFFF, 64'h0000000100000001, 64'h0100000000000000, 8'h00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R7: reset state
    check("R7", res_o, 64'h0);
    check("R7", {56'h0, ovf_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      vec_t e = VECS[v];
      string tag = $sformatf("%s", e[236:205]);
      lane_sel_i = e[204:203];
      {sat_en_i, signed_i, sub_i} = e[202:200];
      a_i = e[199:136];
      b_i = e[135:72];
      @(negedge clk_i);
      check(tag, res_o, e[71:8]);
      check(tag, {56'h0, ovf_o}, {56'h0, e[7:0]});
    end

    // R7: one-cycle latency, output holds previous value before the edge
    lane_sel_i = 2'b00; {sat_en_i, signed_i, sub_i} = 3'b000;
    a_i = 64'h1111111111111111; b_i = 64'h2222222222222222;
    @(posedge clk_i); #1;
    check("R7", res_o, 64'h3333333333333333);
    a_i = 64'h0; #1;
    check("R7", res_o, 64'h3333333333333333);

    // R7: asynchronous reset clears without a clock edge
    @(negedge clk_i); #1;
    rst_ni = 1'b0; #0.5;
    check("R7", res_o, 64'h0);
    check("R7", {56'h0, ovf_o}, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule